// File: doc/BRIEF.md
# Digital Audio Receive Sample Conditioner

This block sits directly behind a digital audio interface receiver (AES3 or S/PDIF style). For every 24-bit sample that the receiver presents with a valid strobe, it applies two corrections. Then it hands the result downstream through a registered output with its own valid strobe.

The first correction is error concealment. The receiver reports three per-sample faults: parity, bi-phase coding and confidence. When any of them is raised, a two-bit software policy selects one of three actions: repeat the last clean sample, output zero, or let the faulty sample through. The second correction is word-length truncation. The receiver supplies a 4-bit code from channel status, and when truncation is enabled the block clears that many low-order bits. Truncation applies only to PCM data: it is skipped when the stream is flagged non-audio. In raw receive mode the block leaves samples completely untouched.

A small tracker state machine owns the last-clean-sample register. It has two states. `ST_LIVE` means the most recent sample was clean. `ST_CONCEAL` means the block is inside a run of concealed samples. It has four transitions:
- `LIVE_TO_CONCEAL`: an erroneous, non-raw sample arrives while in `ST_LIVE`.
- `CONCEAL_TO_LIVE`: a clean sample arrives while in `ST_CONCEAL`.
- `STAY_LIVE`: any other valid or idle cycle in `ST_LIVE`.
- `STAY_CONCEAL`: any other valid or idle cycle in `ST_CONCEAL`.

The register is written only by clean samples, in either state. It resets to zero.

Top module: `rx_sample_cond`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly one clock. After reset, `out_valid` is 0 and `out_sample` is zero.
- R2: With policy code 2'b00 and an erroneous non-raw sample, the output is the most recent clean input sample, or zero if no clean sample has been seen since reset.
- R3: With policy code 2'b01 and an erroneous non-raw sample, the output is all zeros.
- R4: With policy code 2'b10 or 2'b11 and an erroneous non-raw sample, the input sample is output unchanged.
- R5: A sample counts as erroneous when any one of `err_parity`, `err_biphase` or `err_confidence` is 1.
- R6: When `raw_mode` is 1, the input sample is output unchanged: no concealment and no truncation.
- R7: When `trunc_en` is 1, `non_audio` is 0 and `raw_mode` is 0, the lowest N bits of the sample are forced to zero, where N = `aux_len` (word length 24 − N).
- R8: When `non_audio` is 1, no truncation happens, whatever `trunc_en` and `aux_len` are.
- R9: An `aux_len` value above 8 clears exactly 8 low bits, so the shortest word length is 16 bits.
- R10: Truncation is applied after concealment. A held sample is truncated using the current sample's controls.
- R11: On cycles without `in_valid`, `out_sample` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 24 | Received audio sample |
| err_parity | input | 1 | Parity fault for this sample |
| err_biphase | input | 1 | Bi-phase coding fault for this sample |
| err_confidence | input | 1 | Confidence fault for this sample |
| raw_mode | input | 1 | Raw receive mode: bypass all processing |
| non_audio | input | 1 | Stream is flagged as non-PCM |
| aux_len | input | 4 | Channel-status bits to cut from the word |
| hold_policy | input | 2 | Concealment policy: 00 hold, 01 zero, 10/11 pass |
| trunc_en | input | 1 | Enable word-length truncation |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 24 | Conditioned audio sample |

## Verification
The bench sweeps every combination of the following controls, each time with a fresh pseudo-random sample:
- the three error flags;
- all four policy codes;
- raw mode;
- the non-audio flag;
- truncation enable;
- all sixteen auxiliary codes.

Single-flag cases show that each fault alone triggers concealment. Multi-flag cases separate the three policies from one another. Running the same codes in raw mode and with non-audio set shows that each bypass suppresses its own stage. Auxiliary codes 9 to 15 separate saturation from plain masking. Held samples combined with truncation expose the order of the two stages. Idle cycles are inserted throughout the sweep; they confirm the one-cycle strobe delay and that the output holds between strobes.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

    localparam int SAMPLE_W = 24;
    localparam int AUX_W    = 4;
    localparam int MAX_CUT  = 8;

    typedef enum logic [1:0] {
        POL_HOLD     = 2'b00,
        POL_ZERO     = 2'b01,
        POL_PASS     = 2'b10,
        POL_PASS_ALT = 2'b11
    } hold_policy_e;

    typedef enum logic {
        ST_LIVE    = 1'b0,
        ST_CONCEAL = 1'b1
    } track_state_e;

endpackage

// File: rtl/rxc_hold_track.sv
module rxc_hold_track
    import rxc_pkg::*;
#(
    parameter int DATA_W = SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic              smp_err,
    input  logic              smp_raw,
    input  logic [DATA_W-1:0] smp_data,
    output logic [DATA_W-1:0] hold_data,
    output track_state_e      track_state
);

    track_state_e state_q, state_d;
    logic         clean_smp;
    logic         bad_smp;

    assign clean_smp = smp_valid && !smp_err;
    assign bad_smp   = smp_valid && smp_err && !smp_raw;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LIVE: begin
                if (bad_smp) state_d = ST_CONCEAL;       // LIVE_TO_CONCEAL
            end
            ST_CONCEAL: begin
                if (clean_smp) state_d = ST_LIVE;        // CONCEAL_TO_LIVE
            end
            default: state_d = ST_LIVE;
        endcase
    end

    // last clean sample, written in either state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
        end else if (clean_smp) begin
            hold_data <= smp_data;
        end
    end

    assign track_state = state_q;

    // R2
    hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_err) |=> (hold_data == $past(smp_data)));

    // R2
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_valid && !smp_err) |=> $stable(hold_data));

endmodule

// File: rtl/rxc_conceal.sv
module rxc_conceal
    import rxc_pkg::*;
#(
    parameter int DATA_W = SAMPLE_W
) (
    input  logic              smp_err,
    input  logic              smp_raw,
    input  hold_policy_e      policy,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [DATA_W-1:0] hold_data,
    output logic [DATA_W-1:0] fixed_data
);

    always_comb begin
        fixed_data = smp_data;
        if (smp_err && !smp_raw) begin
            unique case (policy)
                POL_HOLD:     fixed_data = hold_data;
                POL_ZERO:     fixed_data = '0;
                POL_PASS:     fixed_data = smp_data;
                POL_PASS_ALT: fixed_data = smp_data;
                default:      fixed_data = smp_data;
            endcase
        end
    end

endmodule

// File: rtl/rxc_trunc.sv
module rxc_trunc
    import rxc_pkg::*;
#(
    parameter int DATA_W = SAMPLE_W,
    parameter int CODE_W = AUX_W,
    parameter int CUT_MAX = MAX_CUT
) (
    input  logic              apply,
    input  logic [CODE_W-1:0] cut_code,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    localparam logic [CODE_W-1:0] CUT_LIMIT = CODE_W'(CUT_MAX);

    logic [CODE_W-1:0] cut_sat;
    logic [DATA_W-1:0] keep;

    assign cut_sat = (cut_code > CUT_LIMIT) ? CUT_LIMIT : cut_code;

    for (genvar i = 0; i < DATA_W; i++) begin : g_keep
        assign keep[i] = !apply || (i >= int'(cut_sat));
    end

    assign dout = din & keep;

endmodule

// File: rtl/rx_sample_cond.sv
module rx_sample_cond
    import rxc_pkg::*;
#(
    parameter int DATA_W  = SAMPLE_W,
    parameter int CODE_W  = AUX_W,
    parameter int CUT_MAX = MAX_CUT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    input  logic              err_parity,
    input  logic              err_biphase,
    input  logic              err_confidence,
    input  logic              raw_mode,
    input  logic              non_audio,
    input  logic [CODE_W-1:0] aux_len,
    input  logic [1:0]        hold_policy,
    input  logic              trunc_en,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sample
);

    logic              any_err;
    logic              do_trunc;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] concealed;
    logic [DATA_W-1:0] shaped;
    track_state_e      trk_state;
    hold_policy_e      pol;

    assign any_err  = err_parity || err_biphase || err_confidence;
    assign do_trunc = trunc_en && !non_audio && !raw_mode;
    assign pol      = hold_policy_e'(hold_policy);

    rxc_hold_track #(.DATA_W(DATA_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid   (in_valid),
        .smp_err     (any_err),
        .smp_raw     (raw_mode),
        .smp_data    (in_sample),
        .hold_data   (hold_q),
        .track_state (trk_state)
    );

    rxc_conceal #(.DATA_W(DATA_W)) u_conceal (
        .smp_err    (any_err),
        .smp_raw    (raw_mode),
        .policy     (pol),
        .smp_data   (in_sample),
        .hold_data  (hold_q),
        .fixed_data (concealed)
    );

    rxc_trunc #(.DATA_W(DATA_W), .CODE_W(CODE_W), .CUT_MAX(CUT_MAX)) u_trunc (
        .apply    (do_trunc),
        .cut_code (aux_len),
        .din      (concealed),
        .dout     (shaped)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_sample <= shaped;
        end
    end

    // R1
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    zero_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && any_err && !raw_mode && hold_policy == 2'b01) |=> (out_sample == '0));

    // R6
    raw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && raw_mode) |=> (out_sample == $past(in_sample)));

    // R9
    min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && do_trunc && aux_len >= CODE_W'(CUT_MAX)) |=> (out_sample[CUT_MAX-1:0] == '0));

    // R11
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sample));

    // R2
    conceal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && any_err && !raw_mode) |=> (trk_state == ST_CONCEAL));

endmodule

// File: tb/rx_sample_cond_bench.sv
module rx_sample_cond_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_sample = '0;
    logic        err_parity = 1'b0, err_biphase = 1'b0, err_confidence = 1'b0;
    logic        raw_mode = 1'b0, non_audio = 1'b0, trunc_en = 1'b0;
    logic [3:0]  aux_len = '0;
    logic [1:0]  hold_policy = 2'b01;
    logic        out_valid;
    logic [23:0] out_sample;

    int n_checks = 0;
    int n_fails  = 0;
    logic [23:0] model_hold = '0;
    logic [23:0] last_out = '0;
    logic [31:0] lcg = 32'h1234_5678;
    bit done = 0;

    always #10 clk = ~clk;

    rx_sample_cond u_rx_sample_cond (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .err_parity(err_parity), .err_biphase(err_biphase), .err_confidence(err_confidence),
        .raw_mode(raw_mode), .non_audio(non_audio), .aux_len(aux_len),
        .hold_policy(hold_policy), .trunc_en(trunc_en),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %06h expected %06h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] expect_out(input logic [23:0] s, input logic e,
            input logic [1:0] p, input logic r, input logic na, input logic te,
            input logic [3:0] a, input logic [23:0] h);
        logic [23:0] v = s;
        int n;
        if (!r) begin
            if (e) begin
                if (p == 2'b00) v = h;
                else if (p == 2'b01) v = '0;
            end
            if (te && !na) begin
                n = (a > 4'd8) ? 8 : int'(a);
                v = v & ~((24'd1 << n) - 24'd1);
            end
        end
        return v;
    endfunction

    task automatic idle_cycle();
        @(negedge clk);
        in_valid = 1'b0;
        in_sample = ~in_sample;
        @(posedge clk);
        #2;
        check(out_valid == 1'b0, "R1", 24'(out_valid), 24'd0);
        check(out_sample == last_out, "R11", out_sample, last_out);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check(out_valid == 1'b0, "R1", 24'(out_valid), 24'd0);
        check(out_sample == '0, "R1", out_sample, 24'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // first sample erroneous under hold policy: reset value is zero
        @(negedge clk);
        in_valid = 1'b1; in_sample = 24'hABCDEF; err_parity = 1'b1; hold_policy = 2'b00;
        @(posedge clk);
        #2;
        check(out_sample == '0, "R2", out_sample, 24'd0);
        last_out = out_sample;
        err_parity = 1'b0;

        for (int pol = 0; pol < 4; pol++)
        for (int cfg = 0; cfg < 8; cfg++)
        for (int aux = 0; aux < 16; aux++)
        for (int ef = 0; ef < 8; ef++) begin
            logic [23:0] exp;
            logic e;
            string tag;
            @(negedge clk);
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            in_valid = 1'b1;
            in_sample = lcg[31:8];
            {err_parity, err_biphase, err_confidence} = 3'(ef);
            {raw_mode, non_audio, trunc_en} = 3'(cfg);
            aux_len = 4'(aux);
            hold_policy = 2'(pol);
            e = (ef != 0);
            exp = expect_out(in_sample, e, hold_policy, raw_mode, non_audio, trunc_en, aux_len, model_hold);
            if (raw_mode) tag = "R6";
            else if (e && pol == 0 && trunc_en && !non_audio && aux != 0) tag = "R10";
            else if (trunc_en && !non_audio && aux > 8) tag = "R9";
            else if (trunc_en && non_audio) tag = "R8";
            else if (trunc_en) tag = "R7";
            else if (e && $countones(3'(ef)) == 1) tag = "R5";
            else if (e && pol == 0) tag = "R2";
            else if (e && pol == 1) tag = "R3";
            else if (e) tag = "R4";
            else tag = "R7";
            @(posedge clk);
            #2;
            check(out_valid == 1'b1, "R1", 24'(out_valid), 24'd1);
            check(out_sample == exp, tag, out_sample, exp);
            last_out = out_sample;
            if (!e) model_hold = in_sample;
            if (ef == 7 && aux[1:0] == 2'b11) idle_cycle();
        end
        done = 1;
    end

    initial begin : watchdog
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule